// File: doc/BRIEF.md
# Transmit Bit-Slip Compensator

This block sits on the transmit side of a serial link, between the parallel data source and the serializer. The receive word aligner locks each time the link comes up and in doing so moves the receive stream by some number of bit positions. That number differs from one lock to the next. This block delays the transmit parallel stream by the complementary number of bit positions, so the two slips always add up to a whole number of words. The round-trip delay through the node therefore stays the same from one lock to the next.

In normal operation the transmit slip follows the slip reported by the word aligner with no software action. A node in master clocking mode reports a receive slip of zero, so its transmit data passes straight through. A small register port lets software read both slips back. Software may also take over the transmit slip with a value of its own. Each word is delayed by one registered cycle plus the slip in bits. The output word in which a new slip first takes effect is marked as possibly corrupted.

Top module: `tx_slip_comp`

## Requirements
- R1: With override off, the applied transmit slip equals (W - r) mod W, where r is the reported receive slip, so receive slip plus transmit slip is a multiple of W (W = word width, 20 by default).
- R2: After reset, the override enable bit (control register bit 0) is 0, the applied slip is 0, and the output word and change flag are 0.
- R3: With the override enable set to 1, the applied slip is the manual value held in control register bits [15:8], whatever the reported receive slip is.
- R4: A manual value of W or larger is applied as W - 1.
- R5: A reported receive slip of W or larger is treated as W - 1, which gives a transmit slip of 1.
- R6: With applied slip s, output bit i of a word equals bit (i - s) of the stream position, one parallel cycle after input: bits i >= s come from the word before, bits i < s come from bit W + i - s of the word before that. Bit 0 is the earliest bit sent.
- R7: A slip of 0, including a receive slip of 0 in master mode, gives an output word equal to the input word of the cycle before, with no bits reordered.
- R8: The change flag is high for exactly the one output word whose slip differs from the slip of the word before it, and is low otherwise.
- R9: With register select 1, read data bits [7:0] hold the receive slip as reported and bits [15:8] hold the applied slip of the current output word. With select 0, bit 0 holds the override enable and bits [15:8] hold the stored manual value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_word_i | input | W | Transmit word in, bit 0 sent first |
| rx_slip_i | input | $clog2(W) | Slip reported by the receive word aligner |
| reg_sel_i | input | 1 | Register select: 0 control, 1 status |
| reg_wr_i | input | 1 | Write strobe for the control register |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| tx_word_o | output | W | Bit-slipped transmit word |
| tx_slip_o | output | $clog2(W) | Slip applied to the present output word |
| slip_chg_o | output | 1 | Present output word may be corrupted by a slip change |

## Verification
A wrong applied-slip register shows up one cycle later in the status field and on tx_slip_o. In the same output word it also shows up as a data word shifted by the wrong amount. The bench compares every steady-state word against a bit-stream model kept from its own past inputs. A wrong history register corrupts the low s bits of the next output word. A missed or extra change flag is caught within the few words that follow a change of receive slip, an override change or a clamp.

// File: rtl/tx_slip_pkg.sv
package tx_slip_pkg;
  // register port geometry
  localparam int REG_W   = 16;
  localparam int MAN_LSB = 8;   // manual value / applied slip field
  localparam int MAN_W   = 8;
  localparam int RX_W    = 8;   // receive slip status field at bit 0

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tx_slip_ctrl.sv
module tx_slip_ctrl
  import tx_slip_pkg::*;
#(
  parameter int W  = 20,
  parameter int SW = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    rx_slip_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic             ovr_o,
  output logic [MAN_W-1:0] man_o,
  output logic [SW-1:0]    slip_o
);
  localparam logic [SW:0]    W_X   = (SW+1)'(W);
  localparam logic [SW-1:0]  MAXS  = SW'(W - 1);
  localparam logic [MAN_W:0] W_MAN = (MAN_W+1)'(W);

  logic             ovr_q, ovr_d;
  logic [MAN_W-1:0] man_q, man_d;
  logic [SW-1:0]    slip_q, slip_d;
  logic [SW-1:0]    rx_c, man_c, auto_s;
  logic [SW:0]      diff;
  logic             ctrl_we;

  assign ctrl_we = reg_wr_i && (reg_sel_i == SEL_CTRL);

  always_comb begin
    ovr_d = ovr_q;
    man_d = man_q;
    if (ctrl_we) begin
      ovr_d = reg_wdata_i[0];
      man_d = reg_wdata_i[MAN_LSB +: MAN_W];
    end
  end

  // slip target: clamp both sources to W-1, complement the receive slip
  always_comb begin
    rx_c   = ({1'b0, rx_slip_i} >= W_X) ? MAXS : rx_slip_i;
    man_c  = ({1'b0, man_q} >= W_MAN) ? MAXS : man_q[SW-1:0];
    diff   = W_X - {1'b0, rx_c};
    auto_s = (rx_c == '0) ? '0 : diff[SW-1:0];
    slip_d = ovr_q ? man_c : auto_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q  <= 1'b0;
      man_q  <= '0;
      slip_q <= '0;
    end else begin
      ovr_q  <= ovr_d;
      man_q  <= man_d;
      slip_q <= slip_d;
    end
  end

  assign ovr_o  = ovr_q;
  assign man_o  = man_q;
  assign slip_o = slip_q;
endmodule

// File: rtl/tx_slip_window.sv
module tx_slip_window #(
  parameter int W  = 20,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  cur_i,
  input  logic [W-1:0]  prev_i,
  input  logic [SW-1:0] slip_i,
  output logic [W-1:0]  win_o
);
  localparam int CW = 2 * W;
  localparam int OW = $clog2(CW + 1);

  logic [CW-1:0] cat;
  logic [CW-1:0] sh;
  logic [OW-1:0] ofs;

  assign cat = {cur_i, prev_i};

  always_comb begin
    ofs = OW'(W) - OW'(slip_i);
    sh  = cat >> ofs;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign win_o[i] = sh[i];
  end
endmodule

// File: rtl/tx_slip_comp.sv
module tx_slip_comp
  import tx_slip_pkg::*;
#(
  parameter int W  = 20,
  parameter int SW = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     tx_word_i,
  input  logic [SW-1:0]    rx_slip_i,
  input  logic             reg_sel_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic [W-1:0]     tx_word_o,
  output logic [SW-1:0]    tx_slip_o,
  output logic             slip_chg_o
);
  logic             ovr_q;
  logic [MAN_W-1:0] man_q;
  logic [SW-1:0]    slip_q;
  logic [W-1:0]     prev_q, win;
  logic [W-1:0]     dout_q;
  logic [SW-1:0]    oslip_q;
  logic             chg_q, chg_d;

  tx_slip_ctrl #(.W(W), .SW(SW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_slip_i(rx_slip_i),
    .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .ovr_o(ovr_q), .man_o(man_q), .slip_o(slip_q)
  );

  tx_slip_window #(.W(W), .SW(SW)) u_win (
    .cur_i(tx_word_i), .prev_i(prev_q), .slip_i(slip_q), .win_o(win)
  );

  assign chg_d = (slip_q != oslip_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      dout_q  <= '0;
      oslip_q <= '0;
      chg_q   <= 1'b0;
    end else begin
      prev_q  <= tx_word_i;
      dout_q  <= win;
      oslip_q <= slip_q;
      chg_q   <= chg_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i == SEL_STAT) begin
      reg_rdata_o[RX_W-1:0]          = RX_W'(rx_slip_i);
      reg_rdata_o[MAN_LSB +: MAN_W]  = MAN_W'(oslip_q);
    end else begin
      reg_rdata_o[0]                 = ovr_q;
      reg_rdata_o[MAN_LSB +: MAN_W]  = man_q;
    end
  end

  assign tx_word_o  = dout_q;
  assign tx_slip_o  = oslip_q;
  assign slip_chg_o = chg_q;
endmodule

// File: rtl/tx_slip_comp_chk.sv
module tx_slip_comp_chk #(
  parameter int W  = 20,
  parameter int SW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  tx_word_i,
  input logic [SW-1:0] rx_slip_i,
  input logic          ovr_q,
  input logic [7:0]    man_q,
  input logic [SW-1:0] slip_q,
  input logic [W-1:0]  tx_word_o,
  input logic [SW-1:0] tx_slip_o,
  input logic          slip_chg_o
);
  function automatic int rx_eff(input logic [SW-1:0] r);
    return (int'(r) >= W) ? W - 1 : int'(r);
  endfunction

  a_r1_complement: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_q |=> ((rx_eff($past(rx_slip_i)) + int'(slip_q)) % W == 0));

  a_r3_manual: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && int'(man_q) < W) |=> (int'(slip_q) == int'($past(man_q))));

  a_r4_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && int'(man_q) >= W) |=> (int'(slip_q) == W - 1));

  a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_slip_o) < W);

  a_r7_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_slip_o == '0) |-> (tx_word_o == $past(tx_word_i)));

  a_r8_flag: assert property (@(posedge clk) disable iff (!rst_n)
    slip_chg_o == (tx_slip_o != $past(tx_slip_o)));
endmodule

bind tx_slip_comp tx_slip_comp_chk #(.W(W), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_word_i(tx_word_i), .rx_slip_i(rx_slip_i),
  .ovr_q(ovr_q), .man_q(man_q), .slip_q(slip_q), .tx_word_o(tx_word_o),
  .tx_slip_o(tx_slip_o), .slip_chg_o(slip_chg_o)
);

// File: tb/tx_slip_comp_tb.sv
module tx_slip_comp_tb;
  localparam int W   = 20;
  localparam int SW  = $clog2(W);
  localparam int CLK = 10;

  logic          clk, rst_n;
  logic [W-1:0]  tx_word_i;
  logic [SW-1:0] rx_slip_i;
  logic          reg_sel_i, reg_wr_i;
  logic [15:0]   reg_wdata_i, reg_rdata_o;
  logic [W-1:0]  tx_word_o;
  logic [SW-1:0] tx_slip_o;
  logic          slip_chg_o;

  int n_run, n_fail;
  logic [W-1:0] h1, h2;
  logic [31:0]  lfsr;

  tx_slip_comp #(.W(W)) u_dut (.*);

  initial clk = 1'b0;
  always #(CLK/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one word per cycle; returns outputs seen after the edge just passed
  task automatic step();
    @(negedge clk);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    tx_word_i = lfsr[W-1:0];
    h2 = h1;
    h1 = tx_word_i;
  endtask

  function automatic logic [W-1:0] model(input int s);
    logic [2*W-1:0] c;
    c = {h1, h2};
    return c[W - s +: W];
  endfunction

  // steady state: n words each checked against the bit-stream model
  task automatic run_check(input int n, input int s, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] e;
      @(negedge clk);
      e = model(s);       // h1 = word before last edge, h2 = one before that
      chk(tx_word_o == e, tag, tx_word_o, e);
      chk(int'(tx_slip_o) == s, tag, tx_slip_o, s);
      chk(!slip_chg_o, {tag, " flag"}, slip_chg_o, 0);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      tx_word_i = lfsr[W-1:0];
      h2 = h1;
      h1 = tx_word_i;
    end
  endtask

  task automatic settle();
    for (int k = 0; k < 4; k++) step();
  endtask

  task automatic reg_write(input logic [15:0] d);
    @(negedge clk);
    reg_sel_i = 1'b0; reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_sel_i = 1'b1;
  endtask

  task automatic read_stat(input int rx, input int tx, input string tag);
    reg_sel_i = 1'b1; #1;
    chk(reg_rdata_o[7:0] == 8'(rx), {tag, " status rx"}, reg_rdata_o[7:0], rx);
    chk(reg_rdata_o[15:8] == 8'(tx), {tag, " status tx"}, reg_rdata_o[15:8], tx);
  endtask

  task automatic t_reset();
    #1;
    chk(tx_word_o == '0, "R2 reset word", tx_word_o, 0);
    chk(tx_slip_o == '0, "R2 reset slip", tx_slip_o, 0);
    chk(!slip_chg_o, "R2 reset flag", slip_chg_o, 0);
    reg_sel_i = 1'b0; #1;
    chk(reg_rdata_o[0] == 1'b0, "R2 reset override", reg_rdata_o[0], 0);
    reg_sel_i = 1'b1;
  endtask

  task automatic t_master_zero();
    rx_slip_i = '0; settle();
    run_check(8, 0, "R7 zero slip pass");
    read_stat(0, 0, "R9 master");
  endtask

  task automatic t_auto(input int rx, input int tx, input string tag);
    rx_slip_i = SW'(rx); settle();
    chk(((rx >= W ? W-1 : rx) + int'(tx_slip_o)) % W == 0, {tag, " R1 sum"}, tx_slip_o, tx);
    run_check(8, tx, {tag, " R6 data"});
    read_stat(rx, tx, {tag, " R9"});
  endtask

  task automatic t_flag(input int rx_new);
    int cnt;
    cnt = 0;
    @(negedge clk); rx_slip_i = SW'(rx_new);
    for (int k = 0; k < 5; k++) begin
      step();
      if (slip_chg_o) cnt++;
    end
    chk(cnt == 1, "R8 one flagged word", cnt, 1);
  endtask

  task automatic t_override(input int man, input int exp, input string tag);
    reg_write({8'(man), 7'd0, 1'b1});
    settle();
    run_check(6, exp, tag);
    reg_sel_i = 1'b0; #1;
    chk(reg_rdata_o[0] == 1'b1, {tag, " R9 ctrl en"}, reg_rdata_o[0], 1);
    chk(reg_rdata_o[15:8] == 8'(man), {tag, " R9 ctrl man"}, reg_rdata_o[15:8], man);
    reg_sel_i = 1'b1;
  endtask

  initial begin
    #(CLK * 50000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    lfsr = 32'h1234_5678;
    h1 = '0; h2 = '0;
    rst_n = 1'b0; tx_word_i = '0; rx_slip_i = '0;
    reg_sel_i = 1'b1; reg_wr_i = 1'b0; reg_wdata_i = '0;
    #(CLK * 3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_master_zero();
    t_auto(5, 15, "R1 rx5");
    t_auto(19, 1, "R1 rx19");
    t_auto(1, 19, "R1 rx1");
    t_flag(7);
    t_auto(7, 13, "R8 after change");
    t_auto(25, 1, "R5 rx25");
    rx_slip_i = SW'(9);
    t_override(3, 3, "R3 manual3");
    t_override(200, W-1, "R4 clamp200");
    t_override(W, W-1, "R4 clampW");
    reg_write(16'h0000);
    settle();
    run_check(6, 11, "R1 override off follows rx9");
    t_flag(0);
    run_check(6, 0, "R7 back to zero");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule